// File: doc/BRIEF.md
# Polarity-Selectable Phase-Frequency Detector

This block compares a reference pulse train with a divided feedback pulse train and turns their relative timing into loop-correction commands for a synthesizer. Each input's rising edge sets its own lead flag. When both flags are set, the detector holds them together for a short fixed spike and then clears them. The flags drive three outputs. The first is a three-state pump command, given as a level plus an output enable. The second is a push-pull comparator output. The third is an open-drain output, given as a single sink-enable: when that signal is 1 the pin pulls low, and otherwise it floats.

A polarity input swaps the sense of the up and down responses. This lets the same loop serve an oscillator whose frequency rises with control voltage and one whose frequency falls with it. The same polarity input chooses which of the two input trains appears on a monitor output. A lock indicator stays high except while exactly one side is leading. Both input trains are sampled in the system clock domain, and a rising edge is a sampled 1 that follows a sampled 0. The edge-history registers reset to 0.

Top module: `pfd_polsel`

## Requirements
- R1: During and after reset, with both inputs low, the lead flags are clear: pump_oe=0, cmp_out=0, od_sink=0, lock_ok=1.
- R2: With pol_sel=1, after a reference rising edge and before any feedback edge: pump_oe=1, pump_lvl=1, cmp_out=0, od_sink=1. The state is visible after the clock edge that samples the new input level.
- R3: With pol_sel=1, after a feedback rising edge and before any reference edge: pump_oe=1, pump_lvl=0, cmp_out=1, od_sink=0.
- R4: With pol_sel=0, the responses of R2 and R3 are exchanged. Reference leading gives pump_lvl=0, cmp_out=1, od_sink=0. Feedback leading gives pump_lvl=1, cmp_out=0, od_sink=1.
- R5: Once both flags are set, either because the lagging edge arrived or because both edges arrived together, they stay set for SPIKE_CYC clocks and then both clear. During that spike pump_oe=0, cmp_out=1, od_sink=1 and lock_ok=1, for either polarity.
- R6: Further rising edges on the leading input while it leads change nothing, so phase error stays within one full cycle either way.
- R7: mon_out follows ref_in when pol_sel=1 and fb_in when pol_sel=0, with no clock delay.
- R8: lock_ok is 0 exactly while one flag is set without the other, and 1 otherwise.
- R9: A change of pol_sel alone leaves the flags unchanged and re-maps the outputs at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Divided reference pulse train |
| fb_in | input | 1 | Divided feedback pulse train |
| pol_sel | input | 1 | 1 = normal sense, 0 = reversed sense and monitor of feedback |
| pump_oe | output | 1 | Pump command drive enable (0 = high impedance) |
| pump_lvl | output | 1 | Pump command level when driven |
| cmp_out | output | 1 | Push-pull comparator output for an external pump |
| od_sink | output | 1 | Open-drain output: 1 pulls low, 0 floats |
| lock_ok | output | 1 | High when no one-sided phase difference is pending |
| mon_out | output | 1 | Monitor of ref_in or fb_in per pol_sel |

## Verification
The detector is driven with reference-leading, feedback-leading and coincident edge patterns under both polarities. Comparing these cases separates a correct polarity swap from a fixed mapping, and separates a real coincidence spike from a missing or stretched one. Repeated edges on the leading side while its flag is held test the saturation that bounds the range. A polarity flip with no new edge shows that pol_sel re-maps the outputs without disturbing the stored state. A reset during a lead shows that the flags clear.

// File: rtl/pfd_polsel.sv
module pfd_polsel #(
  parameter int SPIKE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  input  logic pol_sel,
  output logic pump_oe,
  output logic pump_lvl,
  output logic cmp_out,
  output logic od_sink,
  output logic lock_ok,
  output logic mon_out
);

  localparam int CW = $clog2(SPIKE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SPIKE_CYC - 1);

  logic          ref_d, fb_d;
  logic          up_q, dn_q;
  logic [CW-1:0] cnt;

  wire ref_rise = ref_in & ~ref_d;
  wire fb_rise  = fb_in & ~fb_d;
  wire both     = up_q & dn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_d <= 1'b0;
      fb_d  <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt   <= '0;
    end else begin
      ref_d <= ref_in;
      fb_d  <= fb_in;
      if (both) begin
        if (cnt == LAST) begin
          up_q <= 1'b0;
          dn_q <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else begin
        if (ref_rise) up_q <= 1'b1;
        if (fb_rise)  dn_q <= 1'b1;
      end
    end
  end

  assign pump_oe  = up_q ^ dn_q;
  assign pump_lvl = pol_sel ? up_q : dn_q;
  assign cmp_out  = pol_sel ? dn_q : up_q;
  assign od_sink  = pol_sel ? up_q : dn_q;
  assign lock_ok  = ~(up_q ^ dn_q);
  assign mon_out  = pol_sel ? ref_in : fb_in;

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!pump_oe && !cmp_out && !od_sink && lock_ok));

  p_ref_lead_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_q && !dn_q && ref_rise && !fb_rise) |=> (pump_oe && !lock_ok));

  p_lead_saturates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !dn_q && !fb_rise) |=> (up_q && !dn_q));

  p_spike_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    both |-> (!pump_oe && cmp_out && od_sink && lock_ok));

  p_counter_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !both |-> (cnt == '0));

  p_lock_vs_pump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ok != pump_oe);

  p_pol_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_oe && !ref_rise && !fb_rise) |=> pump_oe);

  always_comb begin
    if (rst_n) p_monitor_r7: assert (mon_out == (pol_sel ? ref_in : fb_in));
  end

endmodule

// File: tb/pfd_polsel_test.sv
module pfd_polsel_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;

  // {ref, fb, pol, exp_oe, exp_lvl, exp_cmp, exp_sink, exp_lock, exp_mon}
  localparam logic [8:0] VEC [NV] = '{
    9'b001000010, 9'b101110101, 9'b001110100, 9'b101110101,
    9'b011001110, 9'b011001110, 9'b001000010,
    9'b011101000, 9'b001101000, 9'b101001111, 9'b101001111, 9'b001000010,
    9'b100101000, 9'b010001111, 9'b010001111, 9'b000000010,
    9'b010110101, 9'b100001110, 9'b100001110, 9'b000000010,
    9'b111001111, 9'b111001111, 9'b001000010,
    9'b101110101, 9'b100101000, 9'b010001111, 9'b010001111, 9'b000000010
  };

  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, fb_in = 1'b0, pol_sel = 1'b1;
  logic pump_oe, pump_lvl, cmp_out, od_sink, lock_ok, mon_out;
  int checks = 0, errors = 0;
  bit done = 0;

  pfd_polsel #(.SPIKE_CYC(2)) uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in), .pol_sel(pol_sel),
    .pump_oe(pump_oe), .pump_lvl(pump_lvl), .cmp_out(cmp_out),
    .od_sink(od_sink), .lock_ok(lock_ok), .mon_out(mon_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic step(input logic r, input logic f, input logic p);
    @(negedge clk);
    ref_in = r; fb_in = f; pol_sel = p;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 pump_oe in reset", pump_oe, 1'b0);
    check("R1 cmp_out in reset", cmp_out, 1'b0);
    check("R1 od_sink in reset", od_sink, 1'b0);
    check("R1 lock_ok in reset", lock_ok, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      string tag;
      v = VEC[i];
      step(v[8], v[7], v[6]);
      tag = $sformatf("row %0d R2/R3/R4/R5/R6/R9", i);
      check({tag, " pump_oe"}, pump_oe, v[5]);
      if (v[5]) check({tag, " pump_lvl"}, pump_lvl, v[4]);
      check({tag, " cmp_out"}, cmp_out, v[3]);
      check({tag, " od_sink"}, od_sink, v[2]);
      check($sformatf("row %0d R8 lock_ok", i), lock_ok, v[1]);
      check($sformatf("row %0d R7 mon_out", i), mon_out, v[0]);
    end

    // R6: feedback leads, repeated feedback edges keep the same state
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    check("R6 fb lead held pump_oe", pump_oe, 1'b1);
    check("R6 fb lead held pump_lvl", pump_lvl, 1'b0);
    check("R6 fb lead held lock_ok", lock_ok, 1'b0);
    // R5: lagging edge starts the spike, which lasts exactly two clocks
    step(1'b1, 1'b0, 1'b1);
    check("R5 spike cycle 1 od_sink", od_sink, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    check("R5 spike cycle 2 cmp_out", cmp_out, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    check("R5 spike ended cmp_out", cmp_out, 1'b0);
    check("R5 spike ended od_sink", od_sink, 1'b0);

    // R1: reset while a lead is pending clears the flags
    step(1'b1, 1'b0, 1'b1);
    check("R2 lead before reset", pump_oe, 1'b1);
    @(negedge clk);
    rst_n = 1'b0; ref_in = 1'b0;
    @(posedge clk);
    #1;
    check("R1 reset clears pump_oe", pump_oe, 1'b0);
    check("R1 reset clears od_sink", od_sink, 1'b0);
    check("R1 reset lock_ok", lock_ok, 1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule